// File: doc/BRIEF.md
# Wait-State Memory Subordinate for AHB-Lite

This block is the memory end of a single AHB-Lite bus segment: a small word array that a manager reads and writes through the usual two-phase protocol. In the address phase it samples address, direction, size and transfer type. In the data phase it either commits the write or presents the read word. Each real transfer's data phase is stretched by a fixed, parameter-chosen number of wait cycles. The bus is 32 bits wide and little-endian. Byte and halfword accesses touch only the byte lanes they select.

Requests the array cannot serve get the protocol's two-cycle ERROR answer and are not carried out. Such requests are an address past the end of the array, a size wider than the bus, or an address not aligned to its size. IDLE and BUSY slots and deselected cycles finish at once with OKAY and touch nothing. Incrementing and wrapping bursts need no special handling, because the manager supplies every beat's address.

Top module: `ahb_wait_mem`

## Requirements
- R1: While and directly after reset, hreadyout is 1, hresp is 0 (OKAY) and hrdata is zero.
- R2: A cycle with hready high that does not present NONSEQ (htrans=2) or SEQ (htrans=3) with hsel high is followed by a cycle with hreadyout 1 and hresp 0, and the array is left unchanged.
- R3: An accepted in-range transfer holds hreadyout low for exactly WAIT_STATES cycles (0 to 3) of its data phase, with hresp 0, and then completes with hreadyout 1.
- R4: A word write (hsize=2) stores the hwdata present in the cycle the data phase completes, at word index haddr[..:2].
- R5: A byte write (hsize=0) updates only lane haddr[1:0]. A halfword write (hsize=1) updates only lanes 0-1 (haddr[1]=0) or lanes 2-3 (haddr[1]=1). Lane n is hwdata bits 8n+7:8n.
- R6: hrdata carries the addressed stored word in the completing cycle of a read and is zero in every other cycle.
- R7: A request with haddr at or past 4*DEPTH_WORDS, hsize above 2, or haddr not a multiple of the access size gets hresp 1 with hreadyout 0, then hresp 1 with hreadyout 1. It writes nothing, and hrdata stays zero.
- R8: Address-phase signals are ignored unless hsel and hready are both high in the same cycle.
- R9: Incrementing and four-beat wrapping bursts, with BUSY slots inserted, store and return each beat at the address the manager gave for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | This subordinate is addressed |
| haddr | input | ADDR_W | Byte address of the transfer |
| htrans | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | 0 byte, 1 halfword, 2 word |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready: the previous transfer has completed |
| hreadyout | output | 1 | This subordinate's ready for its data phase |
| hresp | output | 1 | 0 OKAY, 1 ERROR |
| hrdata | output | 32 | Read data |

## Verification
The assertions assume a single-subordinate bus in which hready is never high while this block holds hreadyout low. They also assume the manager holds hwdata for the whole data phase. The bench builds hready as the block's own hreadyout, forced low only in idle stretches to stand in for another subordinate's stall. Its transfer task advances only when hready was sampled high, and it changes hwdata only at acceptance edges. No burst, BUSY slot or error therefore ever presents an illegal overlap.

// File: rtl/ahbwm_pkg.sv
`timescale 1ns/1ps
package ahbwm_pkg;
   localparam int BUS_W = 32;
   localparam int LANES = BUS_W / 8;

   localparam logic [1:0] TR_IDLE   = 2'd0;
   localparam logic [1:0] TR_BUSY   = 2'd1;
   localparam logic [1:0] TR_NONSEQ = 2'd2;
   localparam logic [1:0] TR_SEQ    = 2'd3;

   localparam logic [2:0] SZ_BYTE = 3'd0;
   localparam logic [2:0] SZ_HALF = 3'd1;
   localparam logic [2:0] SZ_WORD = 3'd2;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DATA = 2'd1,
      PH_ERR1 = 2'd2,
      PH_ERR2 = 2'd3
   } ahbwm_phase_e;
endpackage

// File: rtl/ahbwm_lane_dec.sv
`timescale 1ns/1ps
module ahbwm_lane_dec
   import ahbwm_pkg::*;
(
   input  logic [2:0]       size_i,
   input  logic [1:0]       offs_i,
   output logic [LANES-1:0] lanes_o,
   output logic             reject_o
);
   always_comb begin
      lanes_o  = '0;
      reject_o = 1'b0;
      case (size_i)
         SZ_BYTE: lanes_o = 4'b0001 << offs_i;
         SZ_HALF: begin
            lanes_o  = offs_i[1] ? 4'b1100 : 4'b0011;
            reject_o = offs_i[0];
         end
         SZ_WORD: begin
            lanes_o  = 4'b1111;
            reject_o = |offs_i;
         end
         default: reject_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/ahbwm_wait_ctr.sv
`timescale 1ns/1ps
module ahbwm_wait_ctr #(
   parameter int WAIT_STATES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o
);
   generate
      if (WAIT_STATES == 0) begin : g_no_wait
         assign busy_o = 1'b0;
      end else begin : g_wait
         localparam int CW = $clog2(WAIT_STATES + 1);
         logic [CW-1:0] remain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              remain_q <= '0;
            else if (load_i)         remain_q <= CW'(WAIT_STATES);
            else if (remain_q != '0) remain_q <= remain_q - 1'b1;
         end
         assign busy_o = (remain_q != '0);
      end
   endgenerate
endmodule

// File: rtl/ahbwm_store.sv
`timescale 1ns/1ps
module ahbwm_store
   import ahbwm_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wen_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [LANES-1:0] lanes_i,
   input  logic [BUS_W-1:0] wdata_i,
   output logic [BUS_W-1:0] rdata_o
);
   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         logic [7:0] bank [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
            end else if (wen_i && lanes_i[ln]) begin
               bank[idx_i] <= wdata_i[8*ln +: 8];
            end
         end
         assign rdata_o[8*ln +: 8] = bank[idx_i];
      end
   endgenerate
endmodule

// File: rtl/ahb_wait_mem.sv
`timescale 1ns/1ps
module ahb_wait_mem
   import ahbwm_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DEPTH_WORDS = 16,
   parameter int WAIT_STATES = 2
) (
   input  logic              hclk,
   input  logic              hresetn,
   input  logic              hsel,
   input  logic [ADDR_W-1:0] haddr,
   input  logic [1:0]        htrans,
   input  logic              hwrite,
   input  logic [2:0]        hsize,
   input  logic [BUS_W-1:0]  hwdata,
   input  logic              hready,
   output logic              hreadyout,
   output logic              hresp,
   output logic [BUS_W-1:0]  hrdata
);
   localparam int IDX_W = $clog2(DEPTH_WORDS);
   localparam logic [ADDR_W-3:0] WORD_LIMIT = (ADDR_W-2)'(DEPTH_WORDS);

   generate
      if (WAIT_STATES < 0 || WAIT_STATES > 3) begin : g_bad_wait
         $error("WAIT_STATES must lie in 0..3");
      end
      if (DEPTH_WORDS < 2) begin : g_bad_depth
         $error("DEPTH_WORDS must be at least 2");
      end
      if (ADDR_W < IDX_W + 3) begin : g_bad_addr
         $error("ADDR_W too narrow for DEPTH_WORDS");
      end
   endgenerate

   ahbwm_phase_e     phase_q, phase_d;
   logic [IDX_W-1:0] idx_q;
   logic [LANES-1:0] lanes_q;
   logic             wr_q;

   logic [LANES-1:0] lanes_w;
   logic             shape_bad, beyond, reject, take, start_ok;
   logic             stalled, finishing;
   logic [BUS_W-1:0] word_rd;

   ahbwm_lane_dec u_lanes (
      .size_i   (hsize),
      .offs_i   (haddr[1:0]),
      .lanes_o  (lanes_w),
      .reject_o (shape_bad)
   );

   assign beyond = (haddr[ADDR_W-1:2] >= WORD_LIMIT);
   assign reject = beyond | shape_bad;

   assign hreadyout = !(phase_q == PH_ERR1) && !(phase_q == PH_DATA && stalled);
   assign hresp     = (phase_q == PH_ERR1) || (phase_q == PH_ERR2);

   assign take      = hsel && hready && hreadyout &&
                      ((htrans == TR_NONSEQ) || (htrans == TR_SEQ));
   assign start_ok  = take && !reject;
   assign finishing = (phase_q == PH_DATA) && !stalled;

   ahbwm_wait_ctr #(.WAIT_STATES(WAIT_STATES)) u_wait (
      .clk    (hclk),
      .rst_n  (hresetn),
      .load_i (start_ok),
      .busy_o (stalled)
   );

   always_comb begin
      phase_d = PH_IDLE;
      if (take) phase_d = reject ? PH_ERR1 : PH_DATA;
      case (phase_q)
         PH_DATA: if (stalled) phase_d = PH_DATA;
         PH_ERR1: phase_d = PH_ERR2;
         default: ;
      endcase
   end

   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
         lanes_q <= '0;
         wr_q    <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if (start_ok) begin
            idx_q   <= haddr[IDX_W+1:2];
            lanes_q <= lanes_w;
            wr_q    <= hwrite;
         end
      end
   end

   ahbwm_store #(.DEPTH(DEPTH_WORDS), .IDX_W(IDX_W)) u_store (
      .clk     (hclk),
      .rst_n   (hresetn),
      .wen_i   (finishing && wr_q),
      .idx_i   (idx_q),
      .lanes_i (lanes_q),
      .wdata_i (hwdata),
      .rdata_o (word_rd)
   );

   assign hrdata = (finishing && !wr_q) ? word_rd : '0;
endmodule

// File: rtl/ahbwm_chk.sv
`timescale 1ns/1ps
module ahbwm_chk #(
   parameter int WAIT_STATES = 2
) (
   input logic        hclk,
   input logic        hresetn,
   input logic        hsel,
   input logic        hready,
   input logic [1:0]  htrans,
   input logic        hreadyout,
   input logic        hresp,
   input logic [31:0] hrdata
);
   int low_run;
   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn)                  low_run <= 0;
      else if (!hreadyout && !hresp) low_run <= low_run + 1;
      else                           low_run <= 0;
   end

   AST_WAIT_BOUND: assert property (@(posedge hclk) disable iff (!hresetn)
      (!hreadyout && !hresp) |-> (low_run < WAIT_STATES)); // R3
   AST_IDLE_FAST: assert property (@(posedge hclk) disable iff (!hresetn)
      (hready && !(hsel && htrans >= 2'd2)) |=> (hreadyout && !hresp)); // R2
   AST_ERR_FIRST: assert property (@(posedge hclk) disable iff (!hresetn)
      $rose(hresp) |-> !hreadyout); // R7
   AST_ERR_SECOND: assert property (@(posedge hclk) disable iff (!hresetn)
      (hresp && !hreadyout) |=> (hresp && hreadyout)); // R7
   AST_ERR_NO_DATA: assert property (@(posedge hclk) disable iff (!hresetn)
      hresp |-> (hrdata == 32'd0)); // R7
   AST_RDATA_QUIET: assert property (@(posedge hclk) disable iff (!hresetn)
      !hreadyout |-> (hrdata == 32'd0)); // R6
endmodule

bind ahb_wait_mem ahbwm_chk #(.WAIT_STATES(WAIT_STATES)) u_chk (
   .hclk      (hclk),
   .hresetn   (hresetn),
   .hsel      (hsel),
   .hready    (hready),
   .htrans    (htrans),
   .hreadyout (hreadyout),
   .hresp     (hresp),
   .hrdata    (hrdata)
);

// File: tb/ahb_wait_mem_tb_top.sv
`timescale 1ns/1ps
module ahb_wait_mem_tb_top;
   localparam int WAIT  = 2;
   localparam int DEPTH = 16;

   logic        hclk = 1'b0;
   logic        hresetn;
   logic        hsel = 1'b0;
   logic [31:0] haddr = '0;
   logic [1:0]  htrans = 2'd0;
   logic        hwrite = 1'b0;
   logic [2:0]  hsize = 3'd2;
   logic [31:0] hwdata = '0;
   logic        stall_other = 1'b0;
   logic        hready, hreadyout, hresp;
   logic [31:0] hrdata;

   always #4 hclk = ~hclk;
   assign hready = stall_other ? 1'b0 : hreadyout;

   ahb_wait_mem #(.ADDR_W(32), .DEPTH_WORDS(DEPTH), .WAIT_STATES(WAIT)) dut_i (
      .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
      .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata),
      .hready(hready), .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata));

   int checks = 0;
   int fails  = 0;

   task automatic chk(string req, logic [33:0] act, logic [33:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // behavioural reference: byte array plus a data-phase descriptor
   logic [7:0] mdl_mem [DEPTH*4];
   int  m_kind;   // 0 none, 1 data, 2 first error cycle, 3 second error cycle
   int  m_left, m_addr, m_size;
   bit  m_wr;

   always @(negedge hclk) begin
      if (!hresetn) begin
         m_kind = 0; m_left = 0;
         foreach (mdl_mem[i]) mdl_mem[i] = 8'h00;
         chk("R1", {hreadyout, hresp, hrdata}, {1'b1, 1'b0, 32'h0});
      end else begin
         logic er, ep;
         logic [31:0] ed;
         string tag;
         int base;
         er = !(m_kind == 2) && !(m_kind == 1 && m_left > 0);
         ep = (m_kind >= 2);
         base = (m_addr / 4) * 4;
         ed = (m_kind == 1 && m_left == 0 && !m_wr) ?
              {mdl_mem[base+3], mdl_mem[base+2], mdl_mem[base+1], mdl_mem[base]} : 32'h0;
         if (m_kind == 0) tag = "R2";
         else if (m_kind >= 2) tag = "R7";
         else if (m_left > 0) tag = "R3";
         else tag = m_wr ? "R4" : "R6";
         chk(tag, {hreadyout, hresp, hrdata}, {er, ep, ed});

         if (m_kind == 1 && m_left > 0) m_left--;
         else if (m_kind == 2) m_kind = 3;
         else begin
            if (m_kind == 1 && m_wr)
               for (int b = 0; b < (1 << m_size); b++)
                  mdl_mem[m_addr+b] = hwdata[8*((m_addr+b)%4) +: 8];
            if (hsel && hready && htrans >= 2'd2) begin
               bit bad;
               bad = (int'(hsize) > 2);
               if (!bad) bad = ((haddr % (1 << int'(hsize))) != 0) || (haddr >= 4*DEPTH);
               m_kind = bad ? 2 : 1;
               m_left = WAIT;
               m_addr = haddr;
               m_size = int'(hsize);
               m_wr   = hwrite;
            end else m_kind = 0;
         end
      end
   end

   task automatic xfer(logic [1:0] t, logic [31:0] a, logic w, logic [2:0] s, logic [31:0] d);
      bit acc;
      hsel = 1'b1; htrans = t; haddr = a; hwrite = w; hsize = s;
      do begin
         @(negedge hclk); acc = hready;
         @(posedge hclk); #1;
      end while (!acc);
      if (t >= 2'd2 && w) hwdata = d;
   endtask

   task automatic idle_bus(int n);
      hsel = 1'b0; htrans = 2'd0;
      repeat (n) @(posedge hclk);
      #1;
   endtask

   task automatic read_word(logic [31:0] a, output logic [31:0] data, output int lows);
      xfer(2'd2, a, 1'b0, 3'd2, 32'h0);
      hsel = 1'b0; htrans = 2'd0;
      lows = 0;
      forever begin
         @(negedge hclk);
         if (hreadyout) begin data = hrdata; break; end
         lows++;
      end
      @(posedge hclk); #1;
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge hclk);
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      int lows;
      hresetn = 1'b1;
      #1 hresetn = 1'b0;
      repeat (3) @(posedge hclk);
      #1 hresetn = 1'b1;
      @(negedge hclk);
      chk("R1", {hreadyout, hresp, hrdata}, {1'b1, 1'b0, 32'h0});
      @(posedge hclk); #1;

      // R4 word write, read back; R3 wait count
      xfer(2'd2, 32'h0, 1'b1, 3'd2, 32'h11223344);
      idle_bus(WAIT + 3);
      read_word(32'h0, d, lows);
      chk("R4", {2'b00, d}, {2'b00, 32'h11223344});
      chk("R3", {2'b00, 32'(lows)}, {2'b00, 32'(WAIT)});

      // R5 narrow writes with garbage on idle lanes
      xfer(2'd2, 32'h1, 1'b1, 3'd0, 32'hFFFFAAFF);
      xfer(2'd2, 32'h2, 1'b1, 3'd1, 32'hBEEF5555);
      idle_bus(WAIT + 3);
      read_word(32'h0, d, lows);
      chk("R5", {2'b00, d}, {2'b00, 32'hBEEFAA44});
      xfer(2'd2, 32'h7, 1'b1, 3'd0, 32'h5A000000);
      idle_bus(WAIT + 3);
      read_word(32'h4, d, lows);
      chk("R5", {2'b00, d}, {2'b00, 32'h5A000000});

      // R7 rejected requests leave the array alone
      xfer(2'd2, 32'h8, 1'b1, 3'd2, 32'h0);
      xfer(2'd2, 32'hA, 1'b1, 3'd2, 32'hDEADBEEF);
      xfer(2'd2, 32'h9, 1'b1, 3'd1, 32'h12345678);
      xfer(2'd2, 32'h8, 1'b1, 3'd3, 32'hCAFECAFE);
      idle_bus(WAIT + 3);
      read_word(32'h8, d, lows);
      chk("R7", {2'b00, d}, {2'b00, 32'h0});
      xfer(2'd2, 32'h40, 1'b0, 3'd2, 32'h0);
      hsel = 1'b0; htrans = 2'd0;
      @(negedge hclk);
      chk("R7", {hreadyout, hresp, hrdata}, {1'b0, 1'b1, 32'h0});
      @(negedge hclk);
      chk("R7", {hreadyout, hresp, hrdata}, {1'b1, 1'b1, 32'h0});
      @(posedge hclk); #1;

      // R9 incrementing burst with a BUSY slot, then wrapping burst
      xfer(2'd2, 32'h10, 1'b1, 3'd2, 32'hA0A0A0A0);
      xfer(2'd3, 32'h14, 1'b1, 3'd2, 32'hA1A1A1A1);
      xfer(2'd1, 32'h18, 1'b1, 3'd2, 32'h0);
      xfer(2'd3, 32'h18, 1'b1, 3'd2, 32'hA2A2A2A2);
      xfer(2'd3, 32'h1C, 1'b1, 3'd2, 32'hA3A3A3A3);
      xfer(2'd2, 32'h28, 1'b1, 3'd2, 32'hB0B0B0B0);
      xfer(2'd3, 32'h2C, 1'b1, 3'd2, 32'hB1B1B1B1);
      xfer(2'd3, 32'h20, 1'b1, 3'd2, 32'hB2B2B2B2);
      xfer(2'd3, 32'h24, 1'b1, 3'd2, 32'hB3B3B3B3);
      idle_bus(WAIT + 3);
      read_word(32'h18, d, lows);
      chk("R9", {2'b00, d}, {2'b00, 32'hA2A2A2A2});
      read_word(32'h20, d, lows);
      chk("R9", {2'b00, d}, {2'b00, 32'hB2B2B2B2});
      read_word(32'h2C, d, lows);
      chk("R9", {2'b00, d}, {2'b00, 32'hB1B1B1B1});
      // pipelined read burst, compared cycle by cycle (R6)
      xfer(2'd2, 32'h10, 1'b0, 3'd2, 32'h0);
      xfer(2'd3, 32'h14, 1'b0, 3'd2, 32'h0);
      xfer(2'd3, 32'h18, 1'b0, 3'd2, 32'h0);
      xfer(2'd3, 32'h1C, 1'b0, 3'd2, 32'h0);
      idle_bus(WAIT + 3);

      // R8 request while another subordinate stalls, then while deselected
      hsel = 1'b1; htrans = 2'd2; haddr = 32'h0; hwrite = 1'b1; hsize = 3'd2;
      stall_other = 1'b1;
      repeat (3) @(posedge hclk);
      #1 hwdata = 32'hCAFEF00D;
      stall_other = 1'b0; hsel = 1'b0;
      repeat (2) @(posedge hclk);
      #1 htrans = 2'd0;
      // R2 IDLE and BUSY while selected
      hsel = 1'b1; htrans = 2'd1;
      @(posedge hclk); #1 htrans = 2'd0;
      @(negedge hclk);
      chk("R2", {hreadyout, hresp, hrdata}, {1'b1, 1'b0, 32'h0});
      @(posedge hclk); #1;
      read_word(32'h0, d, lows);
      chk("R8", {2'b00, d}, {2'b00, 32'hBEEFAA44});

      idle_bus(4);
      finish_run();
   end
endmodule